// File: doc/BRIEF.md
# Protection Region Range Decoder

This block turns a bank of protection-region address registers into explicit inclusive byte ranges. Each entry has a 32-bit address register, which holds a byte address divided by four, and a 2-bit matching mode. From these the block works out the first and last byte address of the region on a 34-bit physical address. An entry in top-of-range mode also reads the address register of the entry below it.

All entries are decoded in parallel by combinational logic. One register stage follows, so a permission checker downstream sees stable start, end and active values. The block also registers how many entries are active. Permission evaluation is not part of this block.

Top module: `pmp_rng_decoder`

## Requirements
- R1: While reset is low, every start, end and active output and the active count are zero.
- R2: Mode code 0 (disabled) decodes to start 0 and end 0x3_FFFF_FFFF, with the entry's active flag low.
- R3: Mode code 1 (top of range) decodes to start = previous entry's register × 4 and end = (this register × 4) − 1, taken modulo 2^34. Entry 0 uses zero as its previous register.
- R4: Mode code 2 (naturally aligned 4 bytes) decodes to start = register × 4 and end = start + 3.
- R5: Mode code 3 (naturally aligned power of two) works from t, the number of consecutive ones counted from bit 0 of the register. It clears the low t bits of the register and multiplies by 4 to get the start, and sets end = start + 2^(t+3) − 1.
- R6: In mode code 3, a register of all ones decodes to start 0 and end 0x3_FFFF_FFFF.
- R7: The active count equals the number of entries whose mode code is not 0.
- R8: Every output reflects the inputs sampled at the most recent rising clock edge. A change to the inputs between edges leaves the outputs unchanged.
- R9: The active flag of an entry is high exactly when its mode code is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| areg_i | input | N_ENTRIES*32 | Address registers, entry k at bits [32k+31:32k] |
| amode_i | input | N_ENTRIES*2 | Mode codes, entry k at bits [2k+1:2k] |
| rng_start_o | output | N_ENTRIES*34 | Registered start byte address per entry |
| rng_end_o | output | N_ENTRIES*34 | Registered inclusive end byte address per entry |
| rng_active_o | output | N_ENTRIES | Registered active flag per entry |
| active_cnt_o | output | $clog2(N_ENTRIES+1) | Registered number of active entries |

## Verification
Each decoded range, active flag and count becomes visible one rising edge after the inputs that produce it are sampled. Reset clears all outputs at once, with no edge needed. The bench applies new inputs a quarter period after a rising edge. At that point it checks that the outputs still show the previous edge's result. At the falling edge it compares them with a reference model that captures its values on the same rising edge. As a result, every comparison sees exactly one register of latency.

// File: rtl/pmp_rng_pkg.sv
package pmp_rng_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

endpackage

// File: rtl/pmp_rng_tones.sv
// Priority counter of consecutive ones starting at bit 0.
module pmp_rng_tones #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    logic hit;
    hit   = 1'b0;
    cnt_o = CW'(W);
    for (int k = 0; k < W; k++) begin
      if (!hit && !val_i[k]) begin
        cnt_o = CW'(k);
        hit   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pmp_rng_entry.sv
// Combinational range decode of one entry.
module pmp_rng_entry
  import pmp_rng_pkg::*;
#(
  parameter int AW = 32,
  localparam int PW = AW + 2,
  localparam int TW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] this_i,
  input  logic [AW-1:0] prev_i,
  input  amode_e        mode_i,
  output logic [PW-1:0] start_o,
  output logic [PW-1:0] end_o,
  output logic          active_o
);

  logic [TW-1:0] tones;
  logic [AW-1:0] low_clr;
  logic [PW-1:0] span_mask;
  logic [PW-1:0] this_b;
  logic [PW-1:0] prev_b;
  logic [PW-1:0] napot_base;

  pmp_rng_tones #(.W(AW)) u_tones (
    .val_i (this_i),
    .cnt_o (tones)
  );

  always_comb begin
    for (int k = 0; k < AW; k++) begin
      low_clr[k] = (k < int'(tones));
    end
    for (int k = 0; k < PW; k++) begin
      span_mask[k] = (k < int'(tones) + 3);
    end
  end

  assign this_b     = {this_i, 2'b00};
  assign prev_b     = {prev_i, 2'b00};
  assign napot_base = {this_i & ~low_clr, 2'b00};

  always_comb begin
    active_o = (mode_i != AM_OFF);
    unique case (mode_i)
      AM_TOR: begin
        start_o = prev_b;
        end_o   = this_b - PW'(1);
      end
      AM_NA4: begin
        start_o = this_b;
        end_o   = this_b | PW'(3);
      end
      AM_NAPOT: begin
        start_o = napot_base;
        end_o   = napot_base | span_mask;
      end
      default: begin
        start_o = '0;
        end_o   = '1;
      end
    endcase
  end

endmodule

// File: rtl/pmp_rng_decoder.sv
module pmp_rng_decoder
  import pmp_rng_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int AREG_W    = 32,
  localparam int PA_W     = AREG_W + 2,
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_ENTRIES*AREG_W-1:0] areg_i,
  input  logic [N_ENTRIES*2-1:0]    amode_i,
  output logic [N_ENTRIES*PA_W-1:0] rng_start_o,
  output logic [N_ENTRIES*PA_W-1:0] rng_end_o,
  output logic [N_ENTRIES-1:0]      rng_active_o,
  output logic [CNT_W-1:0]          active_cnt_o
);

  logic [N_ENTRIES*PA_W-1:0] start_d, end_d;
  logic [N_ENTRIES-1:0]      active_d;
  logic [CNT_W-1:0]          cnt_d;
  logic                      upd_en;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [AREG_W-1:0] prev_w;
    if (g == 0) begin : g_first
      assign prev_w = '0;
    end else begin : g_rest
      assign prev_w = areg_i[(g-1)*AREG_W +: AREG_W];
    end
    pmp_rng_entry #(.AW(AREG_W)) u_entry (
      .this_i   (areg_i[g*AREG_W +: AREG_W]),
      .prev_i   (prev_w),
      .mode_i   (amode_e'(amode_i[2*g +: 2])),
      .start_o  (start_d[g*PA_W +: PA_W]),
      .end_o    (end_d[g*PA_W +: PA_W]),
      .active_o (active_d[g])
    );
  end

  always_comb begin
    cnt_d = '0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      cnt_d = cnt_d + CNT_W'(active_d[k]);
    end
  end

  // The stage loads on every cycle; the enable is kept explicit.
  assign upd_en = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rng_start_o  <= '0;
      rng_end_o    <= '0;
      rng_active_o <= '0;
      active_cnt_o <= '0;
    end else if (upd_en) begin
      rng_start_o  <= start_d;
      rng_end_o    <= end_d;
      rng_active_o <= active_d;
      active_cnt_o <= cnt_d;
    end
  end

endmodule

// File: rtl/pmp_rng_decoder_chk.sv
module pmp_rng_decoder_chk #(
  parameter int N_ENTRIES = 8,
  parameter int AREG_W    = 32,
  localparam int PA_W     = AREG_W + 2,
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_ENTRIES*AREG_W-1:0] areg_i,
  input logic [N_ENTRIES*2-1:0]      amode_i,
  input logic [N_ENTRIES*PA_W-1:0]   rng_start_o,
  input logic [N_ENTRIES*PA_W-1:0]   rng_end_o,
  input logic [N_ENTRIES-1:0]        rng_active_o,
  input logic [CNT_W-1:0]            active_cnt_o
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (rst_ni === 1'b0) begin
      p_reset_clear_r1: assert (active_cnt_o == '0 && rng_active_o == '0
                                && rng_start_o == '0 && rng_end_o == '0)
        else $error("outputs not cleared in reset");
    end
  end

  p_cnt_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (int'(active_cnt_o) == $countones(rng_active_o)))
    else $error("count differs from active flags");

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
    logic [PA_W-1:0] s_w, e_w, span_w;
    logic [PA_W:0]   size_w;
    assign s_w    = rng_start_o[g*PA_W +: PA_W];
    assign e_w    = rng_end_o[g*PA_W +: PA_W];
    assign span_w = e_w - s_w;
    assign size_w = {1'b0, span_w} + (PA_W+1)'(1);

    p_active_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> (rng_active_o[g] == ($past(amode_i[2*g +: 2]) != 2'd0)))
      else $error("active flag mismatch");

    p_na4_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(amode_i[2*g +: 2]) == 2'd2) |-> (span_w == PA_W'(3)))
      else $error("four-byte region span wrong");

    p_napot_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(amode_i[2*g +: 2]) == 2'd3)
        |-> (((size_w & {1'b0, span_w}) == '0) && ((s_w & span_w) == '0)))
      else $error("power-of-two region misaligned");

    if (g > 0) begin : g_tor
      p_tor_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(amode_i[2*g +: 2]) == 2'd1
                && $past(amode_i[2*(g-1) +: 2]) == 2'd1)
          |-> (s_w == rng_end_o[(g-1)*PA_W +: PA_W] + PA_W'(1)))
        else $error("top-of-range chain broken");
    end
  end

endmodule

bind pmp_rng_decoder pmp_rng_decoder_chk #(
  .N_ENTRIES (N_ENTRIES),
  .AREG_W    (AREG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .areg_i       (areg_i),
  .amode_i      (amode_i),
  .rng_start_o  (rng_start_o),
  .rng_end_o    (rng_end_o),
  .rng_active_o (rng_active_o),
  .active_cnt_o (active_cnt_o)
);

// File: tb/pmp_rng_decoder_tb.sv
module pmp_rng_decoder_tb;

  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int AW    = 32;
  localparam int PW    = AW + 2;
  localparam int CW    = $clog2(N + 1);
  localparam longint FULL = (64'd1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*AW-1:0] areg_v;
  logic [N*2-1:0]  amode_v;
  logic [N*PW-1:0] st_o, en_o;
  logic [N-1:0]    act_o;
  logic [CW-1:0]   cnt_o;

  bit [31:0] areg[N];
  bit [1:0]  am[N];

  longint exp_s[N];
  longint exp_e[N];
  bit     exp_a[N];
  int     exp_cnt = 0;
  string  exp_tag[N];
  bit     exp_rst = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      areg_v[i*AW +: AW] = areg[i];
      amode_v[2*i +: 2]  = am[i];
    end
  end

  pmp_rng_decoder #(.N_ENTRIES(N), .AREG_W(AW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .areg_i       (areg_v),
    .amode_i      (amode_v),
    .rng_start_o  (st_o),
    .rng_end_o    (en_o),
    .rng_active_o (act_o),
    .active_cnt_o (cnt_o)
  );

  // Behavioural reference: one captured result per rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rst = 1'b1;
      exp_cnt = 0;
      for (int i = 0; i < N; i++) begin
        exp_s[i] = 0; exp_e[i] = 0; exp_a[i] = 0; exp_tag[i] = "R1";
      end
    end else begin
      exp_rst = 1'b0;
      exp_cnt = 0;
      for (int i = 0; i < N; i++) begin
        longint a, p;
        a = longint'(areg[i]);
        p = (i == 0) ? 0 : longint'(areg[i-1]);
        exp_a[i] = (am[i] != 2'd0);
        if (exp_a[i]) exp_cnt++;
        case (am[i])
          2'd0: begin exp_s[i] = 0; exp_e[i] = FULL; exp_tag[i] = "R2"; end
          2'd1: begin exp_s[i] = p * 4; exp_e[i] = (a * 4 - 1) & FULL; exp_tag[i] = "R3"; end
          2'd2: begin exp_s[i] = a * 4; exp_e[i] = a * 4 + 3; exp_tag[i] = "R4"; end
          default: begin
            int t;
            t = 0;
            while (t < 32 && areg[i][t]) t++;
            if (t == 32) begin
              exp_s[i] = 0; exp_e[i] = FULL; exp_tag[i] = "R6";
            end else begin
              exp_s[i] = ((a >> t) << t) * 4;
              exp_e[i] = exp_s[i] + (64'd1 << (t + 3)) - 1;
              exp_tag[i] = "R5";
            end
          end
        endcase
      end
    end
  end

  task automatic compare(input string when);
    for (int i = 0; i < N; i++) begin
      longint gs, ge;
      gs = longint'(st_o[i*PW +: PW]);
      ge = longint'(en_o[i*PW +: PW]);
      checks++;
      if (gs != exp_s[i] || ge != exp_e[i]) begin
        errors++;
        $display("FAIL %s %s entry %0d: start/end %h/%h expected %h/%h",
                 exp_tag[i], when, i, gs, ge, exp_s[i], exp_e[i]);
      end
      checks++;
      if (act_o[i] != exp_a[i]) begin
        errors++;
        $display("FAIL %s %s entry %0d active: got %0b expected %0b",
                 exp_rst ? "R1" : "R9", when, i, act_o[i], exp_a[i]);
      end
    end
    checks++;
    if (int'(cnt_o) != exp_cnt) begin
      errors++;
      $display("FAIL %s %s count: got %0d expected %0d",
               exp_rst ? "R1" : "R7", when, cnt_o, exp_cnt);
    end
  endtask

  always @(negedge clk) compare("edge");

  // Apply new inputs a quarter period after a rising edge; R8: outputs hold.
  task automatic step_in();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic hold_check();
    #1;
    compare("R8-hold");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin areg[i] = 32'h1000 + i; am[i] = 2'd1; end
    repeat (3) @(posedge clk);                 // R1 under reset with live inputs
    step_in(); rst_n = 1'b1;
    // all disabled, nonzero registers (R2)
    step_in();
    for (int i = 0; i < N; i++) begin areg[i] = 32'hA5A5_0000 + i; am[i] = 2'd0; end
    hold_check();
    step_in();
    // top-of-range chain (R3)
    for (int i = 0; i < N; i++) begin areg[i] = 32'h100 * (i + 1); am[i] = 2'd1; end
    hold_check();
    step_in();
    // entry 0 at zero wraps; four-byte regions elsewhere (R3, R4)
    areg[0] = 32'h0; am[0] = 2'd1;
    for (int i = 1; i < N; i++) begin areg[i] = 32'hFFFF_FFF0 + i; am[i] = 2'd2; end
    hold_check();
    step_in();
    // power-of-two corners (R5, R6)
    areg[0] = 32'h0000_0000; areg[1] = 32'h1234_5677; areg[2] = 32'h7FFF_FFFF;
    areg[3] = 32'hFFFF_FFFF; areg[4] = 32'h8000_0001; areg[5] = 32'hFFFF_FFFE;
    areg[6] = 32'h0000_00FF; areg[7] = 32'h3;
    for (int i = 0; i < N; i++) am[i] = 2'd3;
    hold_check();
    step_in();
    // mixed modes, partial count (R7)
    am[0] = 2'd0; am[1] = 2'd1; am[2] = 2'd0; am[3] = 2'd2;
    am[4] = 2'd3; am[5] = 2'd0; am[6] = 2'd1; am[7] = 2'd0;
    hold_check();
    for (int c = 0; c < 300; c++) begin
      step_in();
      for (int i = 0; i < N; i++) begin
        areg[i] = $urandom;
        if (c % 3 == 0) areg[i] = areg[i] | 32'h0000_FFFF >> (c % 17);
        am[i] = 2'($urandom);
      end
      hold_check();
    end
    // asynchronous reset mid-run (R1)
    step_in(); rst_n = 1'b0;
    #1 compare("R1-async");
    repeat (2) @(posedge clk);
    step_in(); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule